// File: doc/BRIEF.md
# Transmit Bit Retimer for a 1200/75 bps FSK Modem

This block lets a host controller that has no serial port feed 1200 bps transmit data one bit at a time. The host places a bit on its data line and pulses its strobe. A rising strobe edge captures the bit into a holding stage. On every internal bit tick the held bit moves into a feed register that drives the modulator. At the same tick the block pulls an active-low ready line to ask for the next bit.

The strobe level at each tick picks the source for the modulator. When the strobe is low at the tick, the modulator takes the retimed feed register. When the strobe is high at the tick, the synchronised host data line drives the modulator directly, so a host that keeps the strobe high sees a plain wire. Retiming exists only in the 1200 bps forward transmit mode. In every other mode the data passes straight through and the ready line stays released.

The bit tick comes from a fractional phase accumulator on the system clock. Its average rate therefore matches the baud rate exactly, even when the clock is not a whole multiple of that rate. Host strobe and data are asynchronous to the system clock and are synchronised before use.

Top module: `tx_bit_retimer`

## Requirements
- R1: After reset, `ready_no` is 1, `mod_bit_o` is 0 and `bit_tick_o` is 0.
- R2: `bit_tick_o` is a single-cycle pulse. The spacing between two consecutive pulses is either floor(CLK_HZ/BAUD) or ceil(CLK_HZ/BAUD) system clock cycles.
- R3: `host_strobe_i` and `host_data_i` pass through a synchroniser of SYNC_STAGES flops (default 2) before any use. In pass-through, `mod_bit_o` follows `host_data_i` within SYNC_STAGES+1 cycles.
- R4: A rising edge of the synchronised strobe captures the synchronised data bit into the holding stage. Data changes without a rising edge leave the captured bit and `mod_bit_o` unchanged while retiming is active.
- R5: In mode 2'b01, a tick that sees the strobe low copies the held bit into the feed register. From the cycle after that tick, `mod_bit_o` equals that bit and `ready_no` is 0.
- R6: In mode 2'b01, a tick that sees the strobe high selects direct drive, so `mod_bit_o` follows the synchronised data line.
- R7: A high synchronised strobe releases `ready_no` to 1 on the next cycle.
- R8: In modes 2'b00 (75 bps back channel), 2'b10 (receive only) and 2'b11 (power down), `mod_bit_o` follows the synchronised data and `ready_no` is 1. Ticks and strobe levels have no effect in these modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_i | input | 2 | Operating mode; 2'b01 is 1200 bps transmit |
| host_strobe_i | input | 1 | Host bit strobe; rising edge loads a bit, level at a tick picks retimed or direct |
| host_data_i | input | 1 | Host transmit data bit |
| mod_bit_o | output | 1 | Bit driven to the FSK modulator |
| bit_tick_o | output | 1 | One-cycle pulse at the 1200 Hz bit rate |
| ready_no | output | 1 | Active-low request for the next bit |

## Verification
A corrupted holding stage shows at `mod_bit_o` one cycle after the next tick taken with the strobe low. Each such tick is therefore compared with the last bit the bench loaded. A wrong source select shows within SYNC_STAGES+1 cycles of a data change, as `mod_bit_o` failing to follow or failing to hold. Accumulator faults show at the first tick gap outside the two legal spacings. Ready faults show one cycle after a tick or after a strobe high.

// File: rtl/txrt_pkg.sv
package txrt_pkg;
  typedef enum logic [1:0] {
    MODE_RX_FWD_TX_BACK = 2'b00,
    MODE_TX_FWD         = 2'b01,
    MODE_RX_FWD_ONLY    = 2'b10,
    MODE_SLEEP          = 2'b11
  } txrt_mode_e;
endpackage

// File: rtl/txrt_sync.sv
module txrt_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] stage_d;
    if (s == 0) begin : g_first
      assign stage_d = d_i;
    end else begin : g_next
      assign stage_d = chain_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= stage_d;
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/txrt_tick.sv
module txrt_tick #(
  parameter int CLK_HZ = 3579545,
  parameter int BAUD   = 1200
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int AW     = $clog2(CLK_HZ + BAUD) + 1;
  localparam int GAP_LO = CLK_HZ / BAUD;
  localparam int GAP_HI = (CLK_HZ + BAUD - 1) / BAUD;
  localparam int GW     = $clog2(GAP_HI + 1) + 1;

  logic [AW-1:0] acc_q, acc_d, sum;
  logic          tick_d, tick_q;

  always_comb begin
    sum    = acc_q + AW'(BAUD);
    tick_d = (sum >= AW'(CLK_HZ));
    acc_d  = tick_d ? sum - AW'(CLK_HZ) : sum;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  logic [GW-1:0] gap_q;
  logic          seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (tick_q) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q < GW'(GAP_HI)) begin
      gap_q  <= gap_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && seen_q) |-> (gap_q == GW'(GAP_LO - 1) || gap_q == GW'(GAP_HI - 1))); // R2
endmodule

// File: rtl/txrt_core.sv
module txrt_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_mode_i,
  input  logic tick_i,
  input  logic strobe_i,
  input  logic data_i,
  output logic mod_bit_o,
  output logic ready_no
);
  logic strobe_q, hold_q, feed_q, sel_q, ready_nq;
  logic hold_d, feed_d, sel_d, ready_nd;
  logic strobe_rise;

  always_comb begin
    strobe_rise = strobe_i & ~strobe_q;
    hold_d      = strobe_rise ? data_i : hold_q;
    feed_d      = tick_i ? hold_q : feed_q;
    sel_d       = sel_q;
    ready_nd    = ready_nq;
    if (!tx_mode_i) begin
      sel_d    = 1'b0;
      ready_nd = 1'b1;
    end else begin
      if (tick_i) sel_d = ~strobe_i;
      if (tick_i && !strobe_i) ready_nd = 1'b0;
      else if (strobe_i)       ready_nd = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      hold_q   <= 1'b0;
      feed_q   <= 1'b0;
      sel_q    <= 1'b0;
      ready_nq <= 1'b1;
    end else begin
      strobe_q <= strobe_i;
      hold_q   <= hold_d;
      feed_q   <= feed_d;
      sel_q    <= sel_d;
      ready_nq <= ready_nd;
    end
  end

  assign mod_bit_o = (tx_mode_i && sel_q) ? feed_q : data_i;
  assign ready_no  = ready_nq;

  AST_HOLD_NO_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !strobe_q) |=> $stable(hold_q)); // R4
  AST_READY_FALL_AT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_no) |-> $past(tick_i && tx_mode_i && !strobe_i)); // R5
  AST_READY_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_no) |-> $past(strobe_i || !tx_mode_i)); // R7
  AST_READY_IDLE_OFF_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_mode_i |=> ready_no); // R8
endmodule

// File: rtl/tx_bit_retimer.sv
module tx_bit_retimer #(
  parameter int CLK_HZ      = 3579545,
  parameter int BAUD        = 1200,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       host_strobe_i,
  input  logic       host_data_i,
  output logic       mod_bit_o,
  output logic       bit_tick_o,
  output logic       ready_no
);
  import txrt_pkg::*;

  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= 2'b00;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [1:0] host_s;
  txrt_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .d_i    ({host_strobe_i, host_data_i}),
    .q_o    (host_s)
  );

  logic tick;
  txrt_tick #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_n_int),
    .tick_o (tick)
  );

  logic tx_mode;
  assign tx_mode = (txrt_mode_e'(mode_i) == MODE_TX_FWD);

  txrt_core u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .tx_mode_i (tx_mode),
    .tick_i    (tick),
    .strobe_i  (host_s[1]),
    .data_i    (host_s[0]),
    .mod_bit_o (mod_bit_o),
    .ready_no  (ready_no)
  );

  assign bit_tick_o = tick;

  AST_TICK_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    bit_tick_o |=> !bit_tick_o); // R2
endmodule

// File: tb/sim_tx_bit_retimer.sv
module sim_tx_bit_retimer;
  localparam int CLK_HZ = 25300;
  localparam int BAUD   = 1200;
  localparam int GAP_LO = CLK_HZ / BAUD;
  localparam int GAP_HI = (CLK_HZ + BAUD - 1) / BAUD;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       strobe = 1'b1;
  logic       data = 1'b0;
  logic       mod_bit, tick, ready_n;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tx_bit_retimer #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .SYNC_STAGES(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .host_strobe_i(strobe),
    .host_data_i(data), .mod_bit_o(mod_bit), .bit_tick_o(tick), .ready_no(ready_n)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic pass_expect(input logic d);
    return d;
  endfunction

  // R2: tick spacing monitor
  int gap = 0;
  bit seen = 1'b0;
  always @(negedge clk) begin
    cycles++;
    if (rst_n && !done) begin
      gap++;
      if (tick) begin
        if (seen) begin
          checks++;
          if (gap != GAP_LO && gap != GAP_HI) begin
            errors++;
            $display("FAIL R2 actual=%0d expected=%0d or %0d", gap, GAP_LO, GAP_HI);
          end
        end
        seen = 1'b1;
        gap = 0;
      end
    end
    if (cycles > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!tick);
  endtask

  task automatic pass_check(input string req, input int n);
    for (int i = 0; i < n; i++) begin
      data = 1'($urandom);
      repeat (4) @(negedge clk);
      chk(req, mod_bit, pass_expect(data));
      chk(req, ready_n, 1'b1);
    end
  endtask

  logic hold_exp;
  logic feed_exp;

  initial begin
    void'($urandom(32'h0000_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", ready_n, 1'b1);
    chk("R1", mod_bit, 1'b0);
    chk("R1", tick, 1'b0);

    // R8: other modes, strobe low and high
    mode = 2'b00; strobe = 1'b0;
    pass_check("R8", 12);
    mode = 2'b10; strobe = 1'b1;
    pass_check("R8", 6);
    mode = 2'b11; strobe = 1'b0;
    pass_check("R8", 6);

    // R3/R6: mode 01, strobe high => direct drive
    mode = 2'b01; strobe = 1'b1;
    pass_check("R6", 12);
    pass_check("R3", 2);

    // Enter retiming: load a known bit, then strobe low
    data = 1'b1;
    repeat (2) @(negedge clk);
    strobe = 1'b0;
    hold_exp = 1'b1; // last rising edge was at reset exit with data 0, then data 1 rise? no rise
    hold_exp = 1'b0;
    repeat (4) @(negedge clk);
    strobe = 1'b1; data = 1'b1;
    repeat (4) @(negedge clk);
    strobe = 1'b0; hold_exp = 1'b1;
    repeat (4) @(negedge clk);

    for (int k = 0; k < 40; k++) begin
      logic nb;
      wait_tick();
      @(posedge clk); #2;
      feed_exp = hold_exp;
      chk("R5", mod_bit, feed_exp);
      chk("R5", ready_n, 1'b0);
      nb = (k < 4) ? logic'(k[0] ^ 1'b1) : 1'($urandom);
      @(negedge clk);
      data = nb;
      @(negedge clk);
      strobe = 1'b1;
      repeat (4) @(negedge clk);
      chk("R7", ready_n, 1'b1);
      strobe = 1'b0;
      hold_exp = nb;
      repeat (2) @(negedge clk);
      data = ~nb;
      repeat (4) @(negedge clk);
      chk("R4", mod_bit, feed_exp);
    end

    // R8: leaving the mode releases ready and restores pass-through
    wait_tick();
    @(posedge clk); #2;
    chk("R5", ready_n, 1'b0);
    @(negedge clk);
    mode = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8", ready_n, 1'b1);
    pass_check("R8", 4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule